// File: doc/BRIEF.md
# Edge-Delta Window Filter for a One-Bit Stream

This block turns a one-bit oversampled stream, one bit per enabled clock, into an 8-bit filtered sample that is refreshed on every enabled clock. The impulse response is a fixed, smooth-edged window 46 bit-periods long. Its coefficients sum to 1024, so a stream of all ones reaches full scale. No per-tap multiply or add is used. The block looks for transitions between neighbouring history bits at twelve fixed bit pairs and turns them into a small signed step. That step then passes through three integrators in series. The third integrator holds the window sum. Dividing it by four gives the sample, and the single overflow value is clipped to the largest 8-bit code.

The stream source drives `bit_in` together with `en` for each new bit. A consumer takes `sample_out` whenever `sample_vld` is high. The valid strobe stays low until the 48-bit history has been filled once after reset.

Top module: `tukey_edge_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the 48-bit history and all three integrators. After it, `sample_out` is 0 and `sample_vld` is 0.
- R2: The history holds positions 0 to 47. Position 0 is the present `bit_in`. Positions 1 to 47 are earlier bits, position k being the bit taken k enabled clocks ago. Each enabled clock moves every bit one position older and discards position 47.
- R3: The step is computed from positions 0 to 47 before the shift. For each of the pairs (0,1), (1,2), (4,5), (42,43), (45,46), (46,47), the pair adds +1 when the newer bit is 1 and the older bit is 0, and adds -1 in the reverse case. For each of the pairs (10,11), (13,14), (14,15), (32,33), (33,34), (36,37), the signs are the other way round. The step always lies between -12 and +12.
- R4: On an enabled clock, integrator A takes A plus the step, B takes B plus the new A, and C takes C plus the new B, all at the same edge. `sample_out` is the current C shifted right by two bits, with 256 clipped to 255.
- R5: While `en` is low, the history, the integrators and `sample_out` hold their values.
- R6: After 46 or more consecutive enabled clocks with `bit_in` high, C equals 1024 and `sample_out` reads 255.
- R7: `sample_vld` is high for exactly those clock cycles that follow an enabled edge at which at least 48 bits had been shifted in since reset (counting the bit taken at that edge). It is low after any edge at which `en` was low.
- R8: After 46 or more consecutive enabled clocks with `bit_in` low, C returns to 0 and `sample_out` reads 0, whatever came before.
- R9: C always stays within 0 to 1024. A stays within -6 to +6, and B stays within -32 to +32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; high when `bit_in` carries a new stream bit |
| bit_in | input | 1 | One-bit stream input, history position 0 |
| sample_out | output | 8 | Filtered sample, clipped C divided by four |
| sample_vld | output | 1 | High for one cycle after each enabled edge once the history has been filled |

## Verification
The assertions assume that `en` and `bit_in` are clean synchronous levels and that reset is held for at least one edge at start. Under those assumptions the step, A, B and C stay inside their bounds whatever the bit pattern is. The stimulus drives every input one time unit after a falling edge, so each is stable at the sampling edge. It mixes random bits at several ones-densities with irregular enable gaps, long runs of all ones and all zeros, and a reset in the middle of a run. Together these reach both clipping limits and every transition pair.

// File: rtl/tukey_edge_pkg.sv
package tukey_edge_pkg;

  // Number of edge-detecting bit pairs.
  localparam int NPAIR = 12;

  // Older index of a pair is always the newer index plus one.
  function automatic int pair_pos(input int idx);
    case (idx)
      0:  return 0;
      1:  return 1;
      2:  return 4;
      3:  return 42;
      4:  return 45;
      5:  return 46;
      6:  return 10;
      7:  return 13;
      8:  return 14;
      9:  return 32;
      10: return 33;
      default: return 36;
    endcase
  endfunction

  // +1: a 1 newer than a 0 adds to the step; -1: reversed.
  function automatic int pair_sign(input int idx);
    return (idx < 6) ? 1 : -1;
  endfunction

  // Scale the window sum down and clip into the output range.
  function automatic int scale_clip(input int total, input int shamt, input int top);
    int q;
    q = total >>> shamt;
    if (q > top) return top;
    if (q < 0) return 0;
    return q;
  endfunction

endpackage

// File: rtl/edge_history.sv
module edge_history #(
  parameter int HLEN = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            bit_in,
  output logic [HLEN-1:0] taps
);
  logic [HLEN-1:1] hist_q;

  assign taps = {hist_q, bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
    end else if (en) begin
      hist_q <= taps[HLEN-2:0];
    end
  end
endmodule

// File: rtl/edge_delta.sv
module edge_delta
  import tukey_edge_pkg::*;
#(
  parameter int HLEN = 48,
  parameter int DW   = 5
) (
  input  logic [HLEN-1:0]        taps,
  output logic signed [DW-1:0]   delta
);
  logic signed [1:0] term [NPAIR];

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    localparam int P = pair_pos(i);
    localparam int S = pair_sign(i);
    logic up, dn;
    assign up = taps[P] & ~taps[P+1];
    assign dn = ~taps[P] & taps[P+1];
    if (S > 0) begin : g_pos
      assign term[i] = up ? 2'sd1 : (dn ? -2'sd1 : 2'sd0);
    end else begin : g_neg
      assign term[i] = up ? -2'sd1 : (dn ? 2'sd1 : 2'sd0);
    end
  end

  always_comb begin
    delta = '0;
    for (int i = 0; i < NPAIR; i++) begin
      delta = delta + DW'(term[i]);
    end
  end
endmodule

// File: rtl/integ_chain.sv
module integ_chain #(
  parameter int DW = 5,
  parameter int AW = 5,
  parameter int BW = 8,
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] delta,
  output logic signed [AW-1:0] acc_a,
  output logic signed [BW-1:0] acc_b,
  output logic signed [CW-1:0] acc_c
);
  logic signed [AW-1:0] a_nx;
  logic signed [BW-1:0] b_nx;
  logic signed [CW-1:0] c_nx;

  always_comb begin
    a_nx = acc_a + AW'(delta);
    b_nx = acc_b + BW'(a_nx);
    c_nx = acc_c + CW'(b_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a <= '0;
      acc_b <= '0;
      acc_c <= '0;
    end else if (en) begin
      acc_a <= a_nx;
      acc_b <= b_nx;
      acc_c <= c_nx;
    end
  end
endmodule

// File: rtl/tukey_edge_filter.sv
module tukey_edge_filter
  import tukey_edge_pkg::*;
#(
  parameter int HLEN  = 48,
  parameter int OUT_W = 8,
  parameter int SHAMT = 2,
  parameter int AW    = 5,
  parameter int BW    = 8,
  parameter int CW    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             bit_in,
  output logic [OUT_W-1:0] sample_out,
  output logic             sample_vld
);
  localparam int DW   = $clog2(NPAIR + 1) + 1;
  localparam int FW   = $clog2(HLEN + 1);
  localparam int OMAX = (1 << OUT_W) - 1;

  logic [HLEN-1:0]        taps;
  logic signed [DW-1:0]   delta;
  logic signed [AW-1:0]   acc_a;
  logic signed [BW-1:0]   acc_b;
  logic signed [CW-1:0]   acc_c;
  logic [FW-1:0]          fill_q;
  logic                   fill_last;

  edge_history #(.HLEN(HLEN)) u_hist (
    .clk(clk), .rst(rst), .en(en), .bit_in(bit_in), .taps(taps)
  );

  edge_delta #(.HLEN(HLEN), .DW(DW)) u_delta (
    .taps(taps), .delta(delta)
  );

  integ_chain #(.DW(DW), .AW(AW), .BW(BW), .CW(CW)) u_integ (
    .clk(clk), .rst(rst), .en(en), .delta(delta),
    .acc_a(acc_a), .acc_b(acc_b), .acc_c(acc_c)
  );

  // The bit taken at this edge completes the history when fill reaches HLEN-1.
  assign fill_last = (fill_q >= FW'(HLEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample_vld <= en & fill_last;
      if (en && fill_q < FW'(HLEN)) fill_q <= fill_q + 1'b1;
    end
  end

  assign sample_out = OUT_W'(scale_clip(int'(acc_c), SHAMT, OMAX));
endmodule

// File: rtl/tukey_edge_chk.sv
module tukey_edge_chk #(
  parameter int DW = 5,
  parameter int AW = 5,
  parameter int BW = 8,
  parameter int CW = 12,
  parameter int OUT_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic signed [DW-1:0] delta,
  input logic signed [AW-1:0] acc_a,
  input logic signed [BW-1:0] acc_b,
  input logic signed [CW-1:0] acc_c,
  input logic [OUT_W-1:0]     sample_out,
  input logic                 sample_vld
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (acc_c == 0 && acc_a == 0 && acc_b == 0 && !sample_vld));

  p_step_range_r3: assert property (@(posedge clk) disable iff (rst)
    (delta >= -12 && delta <= 12));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(sample_out) && $stable(acc_c)));

  p_vld_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sample_vld);

  p_sum_bounds_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_c >= 0 && acc_c <= 1024));

  p_inner_bounds_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_a >= -6 && acc_a <= 6 && acc_b >= -32 && acc_b <= 32));
endmodule

bind tukey_edge_filter tukey_edge_chk #(
  .DW(DW), .AW(AW), .BW(BW), .CW(CW), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .delta(delta),
  .acc_a(acc_a), .acc_b(acc_b), .acc_c(acc_c),
  .sample_out(sample_out), .sample_vld(sample_vld)
);

// File: tb/sim_tukey_edge_filter.sv
module sim_tukey_edge_filter;
  localparam real TCK = 8.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] sample_out;
  logic       sample_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model: window position weights, its own history and accumulators.
  int bh [48];
  int m_b = 0;
  int m_c = 0;
  int m_fill = 0;
  bit m_vld = 1'b0;

  always #(TCK/2) clk = ~clk;

  tukey_edge_filter u0 (
    .clk(clk), .rst(rst), .en(en), .bit_in(bit_in),
    .sample_out(sample_out), .sample_vld(sample_vld)
  );

  // Slope contribution of a bit sitting at a history position (R3 restated).
  function automatic int slope_w(input int pos);
    case (pos)
      0, 1, 4, 42, 45, 46:          return 1;
      10, 13, 14, 32, 33, 36:       return -1;
      default:                      return 0;
    endcase
  endfunction

  function automatic int exp_sample();
    int q;
    q = m_c / 4;
    if (q > 255) q = 255;
    if (q < 0) q = 0;
    return q;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 48; k++) bh[k] = 0;
    m_b = 0; m_c = 0; m_fill = 0; m_vld = 1'b0;
  endtask

  task automatic check(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic tick(input bit e, input bit d, input bit r, input string tag);
    int a;
    @(negedge clk);
    #1;
    en = e; bit_in = d; rst = r;
    @(posedge clk);
    #1;
    if (r) begin
      model_reset();
    end else if (e) begin
      bh[0] = int'(d);
      a = 0;
      for (int k = 0; k < 48; k++) a += slope_w(k) * bh[k];
      m_b += a;
      m_c += m_b;
      m_vld = (m_fill >= 47);
      if (m_fill < 48) m_fill++;
      for (int k = 47; k >= 1; k--) bh[k] = bh[k-1];
    end else begin
      m_vld = 1'b0;
    end
    check({tag, " sample"}, int'(sample_out), exp_sample());
    check("R7 valid", int'(sample_vld), int'(m_vld));
  endtask

  initial begin
    int dens;
    model_reset();
    void'($urandom(32'd1234));
    tick(1'b0, 1'b0, 1'b1, "R1");
    tick(1'b1, 1'b1, 1'b1, "R1");
    check("R1 reset sample", int'(sample_out), 0);
    check("R1 reset valid", int'(sample_vld), 0);

    // Full-scale run of ones: clipped to 255 (R6).
    for (int i = 0; i < 80; i++) tick(1'b1, 1'b1, 1'b0, "R6");
    check("R6 full scale", int'(sample_out), 255);

    // Idle clocks hold everything (R5).
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, 1'b0, "R5");
    check("R5 held value", int'(sample_out), 255);

    // Long zeros return to zero (R8).
    for (int i = 0; i < 80; i++) tick(1'b1, 1'b0, 1'b0, "R8");
    check("R8 back to zero", int'(sample_out), 0);

    // Single isolated one: impulse response shape (R2, R3).
    tick(1'b1, 1'b1, 1'b0, "R2/R3");
    for (int i = 0; i < 50; i++) tick(1'b1, 1'b0, 1'b0, "R2/R3");

    // Random phases with different ones densities and enable gaps (R3, R4, R5).
    for (int ph = 0; ph < 6; ph++) begin
      dens = 10 + ph * 16;
      for (int i = 0; i < 400; i++)
        tick(($urandom % 100) < 80, ($urandom % 100) < dens, 1'b0, "R3/R4");
    end

    // Reset in the middle of activity, then refill (R1, R7).
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b1, 1'b0, "R4");
    tick(1'b1, 1'b1, 1'b1, "R1");
    check("R1 mid reset", int'(sample_out), 0);
    for (int i = 0; i < 60; i++) tick(1'b1, ($urandom % 2) == 1, 1'b0, "R7");
    for (int i = 0; i < 60; i++) tick(1'b1, 1'b1, 1'b0, "R6");
    check("R6 clip again", int'(sample_out), 255);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule